// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Address Walker

This block turns a 32-bit linear address into a physical address by walking the legacy two-level page structures: a directory of 1024 entries and, for ordinary 4 KiB pages, a second table of 1024 entries. A requester presents one request at a time. The request carries the linear address, the access kind (read, write or instruction fetch), the current privilege level and the paging control bits: paging enable, supervisor write protect and large-page enable. It also carries the directory base. The walker fetches entries over a one-outstanding read port. Each read is a one-cycle request pulse, answered later by a one-cycle response-valid with the entry data.

Each request ends with exactly one one-cycle outcome pulse, either done or fault. The physical address, the bytes remaining up to the end of the mapped page, the combined permission bits and a page-fault error code stay on the outputs until the next request is accepted. The block does not update accessed or dirty bits, does not cache translations, and walks only the two-level 32-bit format.

Top module: `pgwalk32`

## Requirements
- R1: With paging disabled, the request completes with done and no memory read. phys_addr equals the linear address zero-extended, bytes_left equals 2^32 minus the linear address, and perm is all ones.
- R2: The first read of a paged walk goes to address {dir_base[31:12], lin[31:22], 2'b00}. The low 12 bits of dir_base are ignored.
- R3: If bit 0 (present) of the directory entry or of the table entry is 0, the walk ends in a fault with pf_code bit 0 equal to 0.
- R4: If directory-entry bit 7 is 1 and big_pages_en is 1, the walk ends after one read. phys_addr = {pde[21:13], pde[31:22], lin[21:0]}, bytes_left = 0x400000 minus lin[21:0], and perm = pde[11:0].
- R5: Otherwise, including when directory-entry bit 7 is 1 but big_pages_en is 0, a second read goes to {pde[31:12], lin[21:12], 2'b00}.
- R6: A completed two-level walk gives phys_addr = {9'b0, pte[31:12], lin[11:0]} and bytes_left = 0x1000 minus lin[11:0]. On every paged outcome, perm is the AND of the low 12 bits of the directory entry and the table entry (the directory entry alone when no table was read).
- R7: A write (req_acc = 2'b01) faults when combined perm bit 1 is 0 and either req_cpl is 3 or wp_en is 1.
- R8: An access with req_cpl = 3 faults when combined perm bit 1... bit 2 (user) is 0.
- R9: pf_code bit 0 is the combined present bit, bit 1 is 1 for a write, bit 2 is 1 for req_cpl = 3, bit 3 is 0, and bit 4 is 1 for a fetch (req_acc = 2'b10). req_acc = 2'b00 is a read.
- R10: Each accepted request produces exactly one of done or fault, high for a single cycle. Fault replaces done whenever any fault condition holds.
- R11: req_ready is high only when idle. req_valid while busy and mem_rsp_valid outside a pending read are ignored, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Walker is idle |
| req_lin | input | 32 | Linear address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_cpl | input | 2 | Current privilege level |
| paging_en | input | 1 | Paging enable |
| wp_en | input | 1 | Supervisor write protect |
| big_pages_en | input | 1 | 4 MiB page enable |
| dir_base | input | 32 | Directory base register value |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Entry address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | Translation completed (one cycle) |
| fault | output | 1 | Translation faulted (one cycle) |
| phys_addr | output | 41 | Physical address |
| bytes_left | output | 33 | Bytes from the address to the end of its page |
| perm | output | 12 | Combined permission bits |
| pf_code | output | 5 | Page-fault error code |

## Verification
The main sweep walks every combination of directory present/writable/user/size bits, table present/writable/user bits, large-page enable, write protect and user versus supervisor privilege, for each of the three access kinds. Addresses and frame numbers are pseudo-random. This separates large from small pages, shows that the size bit is ignored when large pages are disabled, and checks each fault rule on its own. Read latency varies from walk to walk, and some walks have req_valid held high while busy or a stray response while idle; the results must not change. Flat translations at the address-space edges (0, 1, all ones) check the byte-count arithmetic.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DIR_REQ  = 3'd1,
    ST_DIR_WAIT = 3'd2,
    ST_TAB_REQ  = 3'd3,
    ST_TAB_WAIT = 3'd4,
    ST_RESP     = 3'd5
  } walk_state_e;

  typedef enum logic [1:0] {
    FMT_FLAT  = 2'd0,
    FMT_LARGE = 2'd1,
    FMT_SMALL = 2'd2
  } fmt_sel_e;

  // entry bit positions decoded by the walker
  localparam int unsigned ENT_PRESENT = 0;
  localparam int unsigned ENT_WRITE   = 1;
  localparam int unsigned ENT_USER    = 2;
  localparam int unsigned ENT_BIG     = 7;

  // error code bit positions
  localparam int unsigned EC_PRESENT = 0;
  localparam int unsigned EC_WRITE   = 1;
  localparam int unsigned EC_USER    = 2;
  localparam int unsigned EC_FETCH   = 4;

endpackage

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
  import pgwalk_pkg::*;
#(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic [LA_W-1:0]       lin,
  input  logic [LA_W-OFS_W-1:0] dir_frame,
  input  logic [PTE_W-1:0]      pde,
  input  logic                  sel_table,
  output logic [LA_W-1:0]       rd_addr
);

  localparam int unsigned FRAME_W = LA_W - OFS_W;
  localparam int unsigned ENT_SH  = $clog2(PTE_W / 8);

  logic [LA_W-1:0] dir_addr;
  logic [LA_W-1:0] tab_addr;

  // directory index comes from the top bits, table index from the middle bits
  assign dir_addr = {dir_frame, lin[LA_W-1 -: IDX_W], {ENT_SH{1'b0}}};
  assign tab_addr = {pde[PTE_W-1 -: FRAME_W], lin[OFS_W +: IDX_W], {ENT_SH{1'b0}}};

  assign rd_addr = sel_table ? tab_addr : dir_addr;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{lin[OFS_W-1:0], pde[PTE_W-FRAME_W-1:0]};

endmodule

// File: rtl/pgwalk_xlate_fmt.sv
module pgwalk_xlate_fmt
  import pgwalk_pkg::*;
#(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned PA_W  = 41,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic [LA_W-1:0]  lin,
  input  logic [PTE_W-1:0] entry,
  input  fmt_sel_e         sel,
  output logic [PA_W-1:0]  pa,
  output logic [LA_W:0]    bytes_left
);

  localparam int unsigned BYTES_W = LA_W + 1;
  localparam int unsigned BIG_OFS = OFS_W + IDX_W;
  localparam int unsigned BIG_FW  = LA_W - BIG_OFS;
  localparam int unsigned SML_FW  = LA_W - OFS_W;
  localparam int unsigned EXT_W   = PA_W - LA_W;

  logic [PA_W-1:0]    pa_flat, pa_large, pa_small;
  logic [BYTES_W-1:0] by_flat, by_large, by_small;

  assign pa_flat  = PA_W'(lin);
  assign pa_small = PA_W'({entry[PTE_W-1 -: SML_FW], lin[OFS_W-1:0]});

  // large pages take extra physical bits from the entry just above bit OFS_W
  generate
    if (EXT_W > 0) begin : g_ext
      assign pa_large = {entry[OFS_W+1 +: EXT_W], entry[PTE_W-1 -: BIG_FW],
                         lin[BIG_OFS-1:0]};
    end else begin : g_noext
      assign pa_large = PA_W'({entry[PTE_W-1 -: BIG_FW], lin[BIG_OFS-1:0]});
    end
  endgenerate

  assign by_flat  = (BYTES_W'(1) << LA_W)    - BYTES_W'(lin);
  assign by_large = (BYTES_W'(1) << BIG_OFS) - BYTES_W'(lin[BIG_OFS-1:0]);
  assign by_small = (BYTES_W'(1) << OFS_W)   - BYTES_W'(lin[OFS_W-1:0]);

  always_comb begin
    case (sel)
      FMT_LARGE: begin pa = pa_large; bytes_left = by_large; end
      FMT_SMALL: begin pa = pa_small; bytes_left = by_small; end
      default:   begin pa = pa_flat;  bytes_left = by_flat;  end
    endcase
  end

  logic unused_entry;
  assign unused_entry = ^{entry[OFS_W:0]};

endmodule

// File: rtl/pgwalk_perm_check.sv
module pgwalk_perm_check
  import pgwalk_pkg::*;
#(
  parameter int unsigned PERM_W = 12,
  parameter int unsigned EC_W   = 5
) (
  input  logic [PERM_W-1:0] perm,
  input  acc_kind_e         acc,
  input  logic              user_mode,
  input  logic              wp,
  output logic              fault,
  output logic [EC_W-1:0]   code
);

  logic present, is_wr, is_fetch, wr_fault, us_fault;

  assign present  = perm[ENT_PRESENT];
  assign is_wr    = (acc == ACC_WRITE);
  assign is_fetch = (acc == ACC_FETCH);

  // supervisor writes to read-only pages only trap under write protect
  assign wr_fault = is_wr && !perm[ENT_WRITE] && (user_mode || wp);
  assign us_fault = user_mode && !perm[ENT_USER];

  assign fault = !present || wr_fault || us_fault;

  always_comb begin
    code             = '0;
    code[EC_PRESENT] = present;
    code[EC_WRITE]   = is_wr;
    code[EC_USER]    = user_mode;
    code[EC_FETCH]   = is_fetch;
  end

  logic unused_perm;
  assign unused_perm = ^{perm[PERM_W-1:ENT_USER+1]};

endmodule

// File: rtl/pgwalk32.sv
module pgwalk32
  import pgwalk_pkg::*;
#(
  parameter int unsigned LA_W   = 32,
  parameter int unsigned PA_W   = 41,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned PERM_W = 12,
  parameter int unsigned EC_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_lin,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_cpl,
  input  logic              paging_en,
  input  logic              wp_en,
  input  logic              big_pages_en,
  input  logic [LA_W-1:0]   dir_base,
  output logic              mem_req,
  output logic [LA_W-1:0]   mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   phys_addr,
  output logic [LA_W:0]     bytes_left,
  output logic [PERM_W-1:0] perm,
  output logic [EC_W-1:0]   pf_code
);

  localparam int unsigned FRAME_W = LA_W - OFS_W;
  localparam int unsigned BYTES_W = LA_W + 1;
  localparam logic [1:0]  CPL_USER = 2'd3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // state and captured request
  walk_state_e         state_q, state_d;
  logic [LA_W-1:0]     lin_q;
  acc_kind_e           acc_q;
  logic                user_q, wp_q, pse_q, paged_q;
  logic [FRAME_W-1:0]  base_q;
  logic [PTE_W-1:0]    pde_q;
  logic [PA_W-1:0]     pa_q;
  logic [BYTES_W-1:0]  bytes_q;
  logic [PERM_W-1:0]   perm_q;
  logic [EC_W-1:0]     code_q;
  logic                fault_q;

  // next-state controls
  logic                cap_req, load_res, load_pde;
  fmt_sel_e            fmt_sel;
  logic [LA_W-1:0]     fmt_lin;
  logic [PERM_W-1:0]   perm_cur;
  acc_kind_e           chk_acc;
  logic                chk_user, chk_wp;
  logic                rsp_present, rsp_big;

  // datapath results
  logic [PA_W-1:0]     fmt_pa;
  logic [BYTES_W-1:0]  fmt_bytes;
  logic                chk_fault;
  logic [EC_W-1:0]     chk_code;

  assign rsp_present = mem_rsp_data[ENT_PRESENT];
  assign rsp_big     = mem_rsp_data[ENT_BIG] && pse_q;

  always_comb begin
    state_d  = state_q;
    cap_req  = 1'b0;
    load_res = 1'b0;
    load_pde = 1'b0;
    fmt_sel  = FMT_FLAT;
    fmt_lin  = lin_q;
    perm_cur = '1;
    chk_acc  = acc_q;
    chk_user = user_q;
    chk_wp   = wp_q;
    case (state_q)
      ST_IDLE: begin
        fmt_lin  = req_lin;
        chk_acc  = acc_kind_e'(req_acc);
        chk_user = (req_cpl == CPL_USER);
        chk_wp   = wp_en;
        if (req_valid) begin
          cap_req = 1'b1;
          if (paging_en) begin
            state_d = ST_DIR_REQ;
          end else begin
            load_res = 1'b1;
            state_d  = ST_RESP;
          end
        end
      end
      ST_DIR_REQ: state_d = ST_DIR_WAIT;
      ST_DIR_WAIT: begin
        fmt_sel  = FMT_LARGE;
        perm_cur = mem_rsp_data[PERM_W-1:0];
        if (mem_rsp_valid) begin
          if (!rsp_present || rsp_big) begin
            load_res = 1'b1;
            state_d  = ST_RESP;
          end else begin
            load_pde = 1'b1;
            state_d  = ST_TAB_REQ;
          end
        end
      end
      ST_TAB_REQ: state_d = ST_TAB_WAIT;
      ST_TAB_WAIT: begin
        fmt_sel  = FMT_SMALL;
        perm_cur = pde_q[PERM_W-1:0] & mem_rsp_data[PERM_W-1:0];
        if (mem_rsp_valid) begin
          load_res = 1'b1;
          state_d  = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_res) fault_q <= chk_fault;
    end
  end

  // data registers, enabled loads
  always_ff @(posedge clk) begin
    if (cap_req) begin
      lin_q   <= req_lin;
      acc_q   <= acc_kind_e'(req_acc);
      user_q  <= (req_cpl == CPL_USER);
      wp_q    <= wp_en;
      pse_q   <= big_pages_en;
      paged_q <= paging_en;
      base_q  <= dir_base[LA_W-1:OFS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (load_pde) pde_q <= mem_rsp_data;
  end

  always_ff @(posedge clk) begin
    if (load_res) begin
      pa_q    <= fmt_pa;
      bytes_q <= fmt_bytes;
      perm_q  <= perm_cur;
      code_q  <= chk_code;
    end
  end

  pgwalk_addr_gen #(
    .LA_W (LA_W),
    .PTE_W(PTE_W),
    .OFS_W(OFS_W),
    .IDX_W(IDX_W)
  ) u_addr (
    .lin      (lin_q),
    .dir_frame(base_q),
    .pde      (pde_q),
    .sel_table(state_q == ST_TAB_REQ),
    .rd_addr  (mem_addr)
  );

  pgwalk_xlate_fmt #(
    .LA_W (LA_W),
    .PA_W (PA_W),
    .PTE_W(PTE_W),
    .OFS_W(OFS_W),
    .IDX_W(IDX_W)
  ) u_fmt (
    .lin       (fmt_lin),
    .entry     (mem_rsp_data),
    .sel       (fmt_sel),
    .pa        (fmt_pa),
    .bytes_left(fmt_bytes)
  );

  pgwalk_perm_check #(
    .PERM_W(PERM_W),
    .EC_W  (EC_W)
  ) u_perm (
    .perm     (perm_cur),
    .acc      (chk_acc),
    .user_mode(chk_user),
    .wp       (chk_wp),
    .fault    (chk_fault),
    .code     (chk_code)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_DIR_REQ) || (state_q == ST_TAB_REQ);
  assign done       = (state_q == ST_RESP) && !fault_q;
  assign fault      = (state_q == ST_RESP) && fault_q;
  assign phys_addr  = pa_q;
  assign bytes_left = bytes_q;
  assign perm       = perm_q;
  assign pf_code    = code_q;

  logic unused_base;
  assign unused_base = ^{dir_base[OFS_W-1:0]};

endmodule

// File: rtl/pgwalk32_chk.sv
module pgwalk32_chk
  import pgwalk_pkg::*;
#(
  parameter int unsigned LA_W   = 32,
  parameter int unsigned PA_W   = 41,
  parameter int unsigned PERM_W = 12,
  parameter int unsigned EC_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_req,
  input logic              done,
  input logic              fault,
  input logic [PA_W-1:0]   phys_addr,
  input logic [PERM_W-1:0] perm,
  input logic [EC_W-1:0]   pf_code,
  input logic [LA_W-1:0]   lin_q,
  input logic [1:0]        acc_q,
  input logic              user_q,
  input logic              wp_q,
  input logic              paged_q
);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r11_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  a_r1_flat_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !paged_q) |-> (phys_addr == PA_W'(lin_q)));

  a_r3_present_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && paged_q) |-> perm[ENT_PRESENT]);

  a_r7_write_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && paged_q && acc_q == ACC_WRITE && (user_q || wp_q)) |-> perm[ENT_WRITE]);

  a_r8_user_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && paged_q && user_q) |-> perm[ENT_USER]);

  a_r9_code_fields: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (pf_code[EC_WRITE] == (acc_q == ACC_WRITE)) &&
              (pf_code[EC_USER] == user_q) &&
              (pf_code[EC_FETCH] == (acc_q == ACC_FETCH)) &&
              !pf_code[3] && (pf_code[EC_PRESENT] == perm[ENT_PRESENT]));

endmodule

bind pgwalk32 pgwalk32_chk #(
  .LA_W  (LA_W),
  .PA_W  (PA_W),
  .PERM_W(PERM_W),
  .EC_W  (EC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .mem_req  (mem_req),
  .done     (done),
  .fault    (fault),
  .phys_addr(phys_addr),
  .perm     (perm),
  .pf_code  (pf_code),
  .lin_q    (lin_q),
  .acc_q    (acc_q),
  .user_q   (user_q),
  .wp_q     (wp_q),
  .paged_q  (paged_q)
);

// File: tb/pgwalk32_tb.sv
module pgwalk32_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_lin;
  logic [1:0]  req_acc;
  logic [1:0]  req_cpl;
  logic        paging_en, wp_en, big_pages_en;
  logic [31:0] dir_base;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done, fault;
  logic [40:0] phys_addr;
  logic [32:0] bytes_left;
  logic [11:0] perm;
  logic [4:0]  pf_code;

  pgwalk32 u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .req_acc(req_acc), .req_cpl(req_cpl),
    .paging_en(paging_en), .wp_en(wp_en), .big_pages_en(big_pages_en),
    .dir_base(dir_base),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault),
    .phys_addr(phys_addr), .bytes_left(bytes_left),
    .perm(perm), .pf_code(pf_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // memory model state
  logic [31:0] cur_pde, cur_pte, exp_dir_addr, exp_tab_addr, pend_data;
  int          rd_n = 0;
  int          lat = 0;
  int          pend_cnt = -1;
  bit          stray_pulse = 0;

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend_cnt == 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = pend_data;
      pend_cnt      = -1;
    end else if (pend_cnt > 0) begin
      pend_cnt--;
    end
    if (stray_pulse) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hFFFF_FFFF;
      stray_pulse   = 0;
    end
    if (mem_req) begin
      if (rd_n == 0) begin
        check(mem_addr == exp_dir_addr, "R2", "directory read address", mem_addr, exp_dir_addr);
        pend_data = cur_pde;
      end else begin
        check(mem_addr == exp_tab_addr, "R5", "table read address", mem_addr, exp_tab_addr);
        pend_data = cur_pte;
      end
      rd_n++;
      pend_cnt = lat;
    end
  end

  task automatic run_walk(input logic [31:0] va, input logic [31:0] base,
                          input logic [1:0] acc, input logic [1:0] cpl,
                          input bit pg, input bit wp, input bit pse, input bit poke);
    bit          user, wr, fe, big, efault;
    logic [11:0] eperm;
    logic [40:0] epa;
    logic [32:0] eby;
    logic [4:0]  ecode;
    int          ereads, n;
    string       tag;
    user = (cpl == 2'd3);
    wr   = (acc == 2'd1);
    fe   = (acc == 2'd2);
    big  = cur_pde[7] && pse;
    exp_dir_addr = {base[31:12], va[31:22], 2'b00};
    exp_tab_addr = {cur_pde[31:12], va[21:12], 2'b00};
    epa = '0; eby = '0; efault = 0;
    if (!pg) begin
      eperm = 12'hFFF; epa = {9'b0, va}; eby = 33'h1_0000_0000 - {1'b0, va};
      ereads = 0; tag = "R1";
    end else if (!cur_pde[0]) begin
      eperm = cur_pde[11:0]; ereads = 1; tag = "R3";
    end else if (big) begin
      eperm = cur_pde[11:0]; ereads = 1; tag = "R4";
      epa = {cur_pde[21:13], cur_pde[31:22], va[21:0]};
      eby = 33'h40_0000 - {11'b0, va[21:0]};
    end else begin
      eperm = cur_pde[11:0] & cur_pte[11:0]; ereads = 2;
      tag = eperm[0] ? "R6" : "R3";
      epa = {9'b0, cur_pte[31:12], va[11:0]};
      eby = 33'h1000 - {21'b0, va[11:0]};
    end
    if (pg) begin
      if (!eperm[0]) efault = 1;
      else if (wr && !eperm[1] && (user || wp)) begin efault = 1; tag = "R7"; end
      else if (user && !eperm[2]) begin efault = 1; tag = "R8"; end
    end
    ecode = {fe, 1'b0, user, wr, eperm[0]};

    @(negedge clk);
    rd_n = 0;
    req_valid = 1'b1; req_lin = va; req_acc = acc; req_cpl = cpl;
    paging_en = pg; wp_en = wp; big_pages_en = pse; dir_base = base;
    @(negedge clk);
    if (poke) begin
      // R11: requests while busy must be ignored
      req_lin = ~va; req_acc = 2'd0; req_cpl = 2'd0; paging_en = ~pg;
      dir_base = ~base; big_pages_en = ~pse; wp_en = ~wp;
    end else begin
      req_valid = 1'b0;
    end
    n = 0;
    while (!(done || fault) && n < 40) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check(n < 40, "R10", "walk outcome arrives", 64'(n), 64'd40);
    check(!(done && fault), "R10", "done and fault exclusive", {done, fault}, 2'b00);
    check(fault == efault, tag, "fault outcome", fault, efault);
    check(perm == eperm, tag, "combined permission", perm, eperm);
    check(rd_n == ereads, tag, "number of entry reads", 64'(rd_n), 64'(ereads));
    if (efault) begin
      check(pf_code == ecode, "R9", "fault error code", pf_code, ecode);
    end else begin
      check(phys_addr == epa, tag, "physical address", phys_addr, epa);
      check(bytes_left == eby, tag, "bytes left in page", bytes_left, eby);
    end
    @(negedge clk);
    check(!done && !fault, "R10", "outcome lasts one cycle", {done, fault}, 2'b00);
    check(req_ready, "R11", "ready after outcome", req_ready, 1'b1);
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] va, base;
    logic [1:0]  cpl;
    rst_n = 1'b0; req_valid = 1'b0; req_lin = '0; req_acc = '0; req_cpl = '0;
    paging_en = 1'b0; wp_en = 1'b0; big_pages_en = 1'b0; dir_base = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    cur_pde = '0; cur_pte = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready && !done && !fault && !mem_req, "R11", "reset state idle",
          {req_ready, done, fault, mem_req}, 4'b1000);

    // R1: flat translations at edges and in the middle
    run_walk(32'h0000_0000, 32'h0, 2'd0, 2'd0, 0, 0, 0, 0);
    run_walk(32'h0000_0001, 32'h0, 2'd1, 2'd3, 0, 1, 1, 0);
    run_walk(32'hFFFF_FFFF, 32'h0, 2'd2, 2'd3, 0, 1, 0, 0);
    run_walk(32'h1234_5678, 32'h0, 2'd1, 2'd0, 0, 0, 1, 1);

    // near-exhaustive sweep of entry bits and control combinations
    for (int acc = 0; acc < 3; acc++) begin
      for (int f = 0; f < 1024; f++) begin
        cur_pde = (next_rand() & 32'hFFFF_F000) | 32'h20 |
                  (f[3] ? 32'h80 : 32'h0) | {29'b0, f[2], f[1], f[0]};
        cur_pte = (next_rand() & 32'hFFFF_F000) | 32'h40 | {29'b0, f[6], f[5], f[4]};
        base    = next_rand() | 32'h0000_0ABC;
        va      = next_rand();
        cpl     = f[8] ? 2'd3 : 2'(next_rand() % 3);
        lat     = f % 3;
        if (f % 11 == 0) begin
          // R11: stray response while idle
          @(negedge clk);
          stray_pulse = 1;
          repeat (2) @(negedge clk);
        end
        run_walk(va, base, 2'(acc), cpl, 1, f[9], f[7], (f % 7) == 0);
      end
    end

    // R4 boundary: last byte and first byte of a large page
    cur_pde = 32'hABC0_0000 | 32'h0035_E000 | 32'h87;
    lat = 1;
    run_walk(32'h003F_FFFF, 32'h0000_5000, 2'd0, 2'd3, 1, 0, 1, 0);
    run_walk(32'h0040_0000, 32'h0000_5000, 2'd1, 2'd3, 1, 1, 1, 0);
    // R6 boundary: last byte of a small page
    cur_pde = 32'h0001_2007; cur_pte = 32'h0007_7007;
    run_walk(32'h0000_0FFF, 32'h0000_6000, 2'd2, 2'd0, 1, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule